// File: doc/BRIEF.md
# Memory Tag Check Unit

This block sits beside a load/store path and decides, one access at a time, whether a memory access may proceed. Each access arrives with its 64-bit virtual address, a flag telling whether the target page is marked as tag-enabled, and the 4-bit allocation tag that tag storage returned for the addressed 16-byte granule. Tag storage looks up that tag using the address with its low 4 bits dropped. The unit takes the pointer's own tag from address bits 59..56 and compares it with the stored tag. A mismatch is then handled according to the current context's fault mode and a check-override bit.

Requests enter on a valid/ready channel and each one produces exactly one response on a second valid/ready channel, one cycle after acceptance. The response says whether the access is allowed. In precise mode it also flags a synchronous fault and carries the faulting address. Deferred faults are gathered in a sticky pending flag that carries no address and stays set until software-side logic pulses the clear input. The fault mode and override bit are plain control inputs and are sampled in the cycle a request is accepted.

Back-pressure: `req_ready` is high whenever the response register is empty or is being drained in the same cycle (`!rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value and no new request is taken.

Top module: `mtc_tag_check`

## Requirements
- R1: The pointer tag is address bits 59..56 and is compared for equality with the 4-bit allocation tag. No pointer tag value (including 0 or 15) matches any stored tag other than itself.
- R2: When `req_tagged` is 0, the access is allowed with no synchronous fault and no change to the pending flag, whatever the tags are.
- R3: When `chk_override` is 1 at acceptance, the access is allowed with no synchronous fault and no change to the pending flag.
- R4: Mode encoding is 0 = ignore, 1 = precise, 2 = deferred, 3 = same as ignore. In ignore mode a mismatch is allowed and raises nothing.
- R5: In precise mode a checked mismatch gives `rsp_allow`=0, `rsp_sync_fault`=1 and `rsp_fault_addr` equal to the full 64-bit request address. Whenever `rsp_sync_fault` is 0, `rsp_fault_addr` is 0.
- R6: In deferred mode a checked mismatch is allowed with `rsp_sync_fault`=0. `async_pending` is 1 from the cycle in which the response appears.
- R7: `async_pending` stays 1 until `async_clr` is pulsed, and it is 0 the cycle after a clear. Further deferred mismatches while it is set leave it at 1. A deferred mismatch accepted in the same cycle as a clear leaves it at 1.
- R8: The response appears in the cycle after acceptance, `req_ready` = `!rsp_valid || rsp_ready`, and a stalled response holds all of its outputs stable.
- R9: After reset, `rsp_valid` and `async_pending` are 0 and `req_ready` is 1.
- R10: When the tags match, the access is allowed with no fault in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Unit can accept a request |
| req_addr | input | 64 | Virtual address of the access, tag in bits 59..56 |
| req_tagged | input | 1 | Target page carries the tagged attribute |
| req_alloc_tag | input | 4 | Allocation tag stored for the addressed granule |
| fault_mode | input | 2 | 0 ignore, 1 precise, 2 deferred, 3 ignore |
| chk_override | input | 1 | 1 disables checking |
| async_clr | input | 1 | Clears the pending deferred fault |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_allow | output | 1 | Access may be performed |
| rsp_sync_fault | output | 1 | Precise tag fault |
| rsp_fault_addr | output | 64 | Faulting address, 0 when no precise fault |
| async_pending | output | 1 | Sticky deferred fault flag |

## Verification
The assertions assume that `fault_mode`, `chk_override` and `async_clr` are sampled only at the clock edge. They also assume that a consumer that deasserts `rsp_ready` still lets the unit hold its response, so the hold property compares each stalled cycle with the one before. The bench changes every input on the falling edge and keeps `req_valid` asserted through a stall, so the inputs stay within these assumptions. Random stimulus draws all four mode codes, both page flags, override settings and clear pulses. It biases allocation tags so that about half of the accesses match, which exercises both the match and mismatch paths in every mode.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF      = 2'd0,
    MODE_PRECISE  = 2'd1,
    MODE_DEFERRED = 2'd2,
    MODE_RSVD     = 2'd3
  } fault_mode_e;

  typedef struct packed {
    logic allow;
    logic sync_fault;
    logic async_hit;
  } verdict_t;
endpackage

// File: rtl/mtc_compare.sv
module mtc_compare
  import mtc_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0] ptr_tag,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             page_tagged,
  input  logic             override,
  input  logic [1:0]       mode,
  output verdict_t         verdict
);
  fault_mode_e m;
  logic        checking;
  logic        mismatch;

  always_comb begin
    m        = fault_mode_e'(mode);
    checking = page_tagged && !override &&
               (m == MODE_PRECISE || m == MODE_DEFERRED);
    mismatch = checking && (ptr_tag != alloc_tag);
    verdict.sync_fault = mismatch && (m == MODE_PRECISE);
    verdict.async_hit  = mismatch && (m == MODE_DEFERRED);
    verdict.allow      = !verdict.sync_fault;
  end
endmodule

// File: rtl/mtc_resp_stage.sv
module mtc_resp_stage
  import mtc_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  verdict_t          in_verdict,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_allow,
  output logic              out_sync_fault,
  output logic [ADDR_W-1:0] out_fault_addr
);
  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_allow      <= 1'b0;
      out_sync_fault <= 1'b0;
      out_fault_addr <= '0;
    end else if (load) begin
      out_valid      <= 1'b1;
      out_allow      <= in_verdict.allow;
      out_sync_fault <= in_verdict.sync_fault;
      out_fault_addr <= in_verdict.sync_fault ? in_addr : '0;
    end else if (out_ready) begin
      out_valid      <= 1'b0;
    end
  end
endmodule

// File: rtl/mtc_async_flag.sv
module mtc_async_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/mtc_tag_check.sv
module mtc_tag_check
  import mtc_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int TAG_W   = 4,
  parameter int TAG_LSB = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_tagged,
  input  logic [TAG_W-1:0]  req_alloc_tag,
  input  logic [1:0]        fault_mode,
  input  logic              chk_override,
  input  logic              async_clr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_allow,
  output logic              rsp_sync_fault,
  output logic [ADDR_W-1:0] rsp_fault_addr,
  output logic              async_pending
);
  localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

  verdict_t verdict;
  logic     accept;

  mtc_compare #(.TAG_W(TAG_W)) u_cmp (
    .ptr_tag     (req_addr[TAG_MSB:TAG_LSB]),
    .alloc_tag   (req_alloc_tag),
    .page_tagged (req_tagged),
    .override    (chk_override),
    .mode        (fault_mode),
    .verdict     (verdict)
  );

  mtc_resp_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (req_valid),
    .in_ready       (req_ready),
    .in_verdict     (verdict),
    .in_addr        (req_addr),
    .out_valid      (rsp_valid),
    .out_ready      (rsp_ready),
    .out_allow      (rsp_allow),
    .out_sync_fault (rsp_sync_fault),
    .out_fault_addr (rsp_fault_addr)
  );

  assign accept = req_valid && req_ready;

  mtc_async_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (accept && verdict.async_hit),
    .clr_i  (async_clr),
    .flag_o (async_pending)
  );
endmodule

// File: rtl/mtc_tag_check_chk.sv
module mtc_tag_check_chk #(
  parameter int ADDR_W = 64,
  parameter int TAG_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_tagged,
  input logic [1:0]        fault_mode,
  input logic              chk_override,
  input logic              async_clr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic              rsp_allow,
  input logic              rsp_sync_fault,
  input logic [ADDR_W-1:0] rsp_fault_addr,
  input logic              async_pending
);
  logic fire;
  assign fire = req_valid && req_ready;

  p_untagged_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !req_tagged |=> rsp_valid && rsp_allow && !rsp_sync_fault);

  p_override_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire && chk_override |=> rsp_valid && rsp_allow && !rsp_sync_fault);

  p_ignore_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fire && (fault_mode == 2'd0 || fault_mode == 2'd3) |=> rsp_allow && !rsp_sync_fault);

  p_sync_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_sync_fault |-> !rsp_allow);

  p_addr_only_on_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_sync_fault |-> rsp_fault_addr == '0);

  p_deferred_allows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fire && fault_mode == 2'd2 |=> rsp_allow && !rsp_sync_fault);

  p_pending_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    async_pending && !async_clr |=> async_pending);

  p_clear_works_r7: assert property (@(posedge clk) disable iff (!rst_n)
    async_clr && !(fire && fault_mode == 2'd2) |=> !async_pending);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_allow) &&
      $stable(rsp_sync_fault) && $stable(rsp_fault_addr));

  p_ready_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));

  p_resp_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
endmodule

bind mtc_tag_check mtc_tag_check_chk #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (.*);

// File: tb/tb_mtc_tag_check.sv
`timescale 1ns/1ps
module tb_mtc_tag_check;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        req_tagged = 1'b0;
  logic [3:0]  req_alloc_tag = '0;
  logic [1:0]  fault_mode = '0;
  logic        chk_override = 1'b0;
  logic        async_clr = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_allow;
  logic        rsp_sync_fault;
  logic [63:0] rsp_fault_addr;
  logic        async_pending;

  int checks = 0;
  int errors = 0;
  logic exp_async = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mtc_tag_check dut (.*);

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ptag(logic [63:0] a);
    return a[59:56];
  endfunction

  // expected {valid, allow, sync} and address for one accepted access
  task automatic xact(logic [63:0] a, logic tg, logic [3:0] at, logic [1:0] md,
                      logic ov, logic clr, string req);
    logic chk, mis, es, ea;
    @(negedge clk);
    req_addr = a; req_tagged = tg; req_alloc_tag = at; fault_mode = md;
    chk_override = ov; async_clr = clr; req_valid = 1'b1; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; async_clr = 1'b0;
    chk = tg && !ov && (md == 2'd1 || md == 2'd2);
    mis = chk && (ptag(a) != at);
    es  = mis && md == 2'd1;
    ea  = mis && md == 2'd2;
    exp_async = ea | (exp_async & ~clr);
    check(req, {125'd0, rsp_valid, rsp_allow, rsp_sync_fault}, {125'd0, 1'b1, !es, es});
    check(req, {64'd0, rsp_fault_addr}, {64'd0, es ? a : 64'd0});
    check(req, {127'd0, async_pending}, {127'd0, exp_async});
  endtask

  function automatic logic [63:0] mk(logic [3:0] t, logic [59:0] low);
    return {4'h0, t, low[55:0]};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] a;
    logic [3:0]  at;
    logic        tg, ov, clr;
    logic [1:0]  md;
    void'($urandom(32'h1A5E_0042));
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", {125'd0, rsp_valid, async_pending, req_ready}, {125'd0, 3'b001});
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", {125'd0, rsp_valid, async_pending, req_ready}, {125'd0, 3'b001});

    // R10 matching tags in each mode
    for (int m = 0; m < 4; m++) xact(mk(4'h7, 60'h123_4560), 1, 4'h7, m[1:0], 0, 0, "R10");
    // R1 no wildcard: pointer tag 0 and 15
    xact(mk(4'h0, 60'h0_0010), 1, 4'h5, 2'd1, 0, 0, "R1");
    xact(mk(4'hF, 60'hA_BCD0), 1, 4'h0, 2'd1, 0, 0, "R1");
    xact(mk(4'h3, 60'h40), 1, 4'h2, 2'd1, 0, 0, "R1");
    // R2 untagged page, R3 override
    xact(mk(4'h9, 60'h80), 0, 4'h1, 2'd1, 0, 0, "R2");
    xact(mk(4'h9, 60'h80), 0, 4'h1, 2'd2, 0, 0, "R2");
    xact(mk(4'h9, 60'h90), 1, 4'h1, 2'd1, 1, 0, "R3");
    xact(mk(4'h9, 60'h90), 1, 4'h1, 2'd2, 1, 0, "R3");
    // R4 ignore and reserved code
    xact(mk(4'hC, 60'hF0), 1, 4'h2, 2'd0, 0, 0, "R4");
    xact(mk(4'hC, 60'hF0), 1, 4'h2, 2'd3, 0, 0, "R4");
    // R5 precise fault address, high bits set
    xact(64'hF3A5_0000_DEAD_BEE8, 1, 4'h0, 2'd1, 0, 0, "R5");
    // R6 deferred sets pending, R7 sticky and clear
    xact(mk(4'h1, 60'h100), 1, 4'h2, 2'd2, 0, 0, "R6");
    xact(mk(4'h1, 60'h110), 1, 4'h3, 2'd2, 0, 0, "R7");
    xact(mk(4'h1, 60'h120), 1, 4'h1, 2'd1, 0, 0, "R7");
    @(negedge clk); async_clr = 1'b1;
    @(negedge clk); async_clr = 1'b0; exp_async = 1'b0;
    check("R7", {127'd0, async_pending}, {127'd0, 1'b0});
    xact(mk(4'h4, 60'h130), 1, 4'h5, 2'd2, 0, 0, "R6");
    xact(mk(4'h4, 60'h140), 1, 4'h6, 2'd2, 0, 1, "R7");  // clear and set together

    // R8 stall: first response held, second waits
    @(negedge clk);
    req_addr = 64'h0B00_0000_0000_0100; req_tagged = 1; req_alloc_tag = 4'h1;
    fault_mode = 2'd1; chk_override = 0; req_valid = 1; rsp_ready = 0;
    @(negedge clk);
    req_addr = 64'h0200_0000_0000_0200; req_alloc_tag = 4'h2;
    check("R8", {125'd0, rsp_valid, rsp_sync_fault, req_ready}, {125'd0, 3'b110});
    check("R8", {64'd0, rsp_fault_addr}, {64'd0, 64'h0B00_0000_0000_0100});
    repeat (2) @(negedge clk);
    check("R8", {125'd0, rsp_valid, rsp_sync_fault, req_ready}, {125'd0, 3'b110});
    check("R8", {64'd0, rsp_fault_addr}, {64'd0, 64'h0B00_0000_0000_0100});
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    check("R8", {125'd0, rsp_valid, rsp_allow, rsp_sync_fault}, {125'd0, 3'b110});
    check("R8", {64'd0, rsp_fault_addr}, {64'd0, 64'd0});

    // random mix
    for (int i = 0; i < 400; i++) begin
      a   = {$urandom, $urandom};
      at  = ($urandom % 2) ? ptag(a) : 4'($urandom);
      tg  = ($urandom % 4) != 0;
      ov  = ($urandom % 5) == 0;
      md  = 2'($urandom);
      clr = ($urandom % 8) == 0;
      xact(a, tg, at, md, ov, clr, "R1/R5/R6/R7 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule